// File: doc/BRIEF.md
# Compare-Match General-Purpose Timer

An up-counting timer with a word-addressed register port. A control field picks one of three external tick streams (peripheral, high-frequency, slow 32 kHz). A 12-bit prescaler divides the chosen stream, and each divided tick advances the counter by one. Three compare channels each raise a status flag when the counter steps onto their value. A rollover flag marks the step from the all-ones value to zero. Status flags are cleared by writing ones. Each flag has an enable bit, and the OR of enabled, pending flags drives one level interrupt, gated by the timer enable.

Two counting modes are available. In free-run mode the counter wraps across its whole range. In restart mode, compare channel 1 sets the period: the step after the counter reaches that value returns it to zero, and writing compare 1 restarts the count at once. An enable-mode bit chooses whether turning the timer on restarts the count or resumes it. A software-reset bit in the control word clears most of the block's state but keeps the clock-source and mode choices that were written with it. Capture inputs are not built, and their registers read as zero.

Top module: `cmp_timer`

## Requirements
- R1: Word index = address bits [5:2]. The words, in order, are: control 0, prescaler 1, status 2, interrupt enable 3, compare 1..3 at 4..6, capture 1..2 at 7..8, counter 9. Capture words read 0 and ignore writes. The counter word is read-only, and writes to it have no effect.
- R2: Control bits [8:6] select the tick source: 001 = tick_ipg_i, 010 = tick_hf_i, 100 = tick_slow_i. Every other code selects nothing, and the counter holds. Ticks from the sources that are not selected have no effect.
- R3: With the timer enabled (control bit 0), the counter advances by one after every (prescaler + 1) ticks of the selected source.
- R4: Status bit layout: [2:0] compare 1..3, [4:3] capture (always 0), [5] rollover. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R5: The interrupt-enable register uses the status layout. irq_o is 1 exactly when some status bit and its enable bit are both 1 and control bit 0 is 1.
- R6: A compare flag is set on the counting step that makes the counter equal to that channel's compare value.
- R7: With control bit 9 (free-run) at 0, the step taken while the counter equals compare 1 returns the counter to 0.
- R8: The step from the all-ones counter value to 0 sets the rollover flag (status bit 5).
- R9: With control bit 9 at 0, a write to compare 1 resets the counter to 0.
- R10: When control bit 0 changes from 0 to 1, the counter restarts from 0 if control bit 1 (enable mode) is set, and otherwise resumes from its held value.
- R11: A control write with bit 15 set clears control bits 0, 1, 3, 5, 16 and 17. It also clears status, interrupt enable, prescaler and counter, and sets all three compare registers to all ones. The other control bits keep the written value. Bit 15 clears itself on the next cycle.
- R12: Control bits 2, 4 and 10..14 are not stored and read 0. The asynchronous reset sets every register to zero, the compare registers included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address; bits [5:2] select the word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| tick_ipg_i | input | 1 | Peripheral-clock tick enable |
| tick_hf_i | input | 1 | High-frequency tick enable |
| tick_slow_i | input | 1 | 32 kHz tick enable |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong prescaler phase or a bad counter increment appears in the counter word on the very next read after the tick burst that should have moved it by a known amount. A flag set one step early or late, or a clear that loses to a set, shows up at once in the status word and on irq_o, because the interrupt is a direct combination of stored state. A restart or reset that fires when it should not, or fails to fire, leaves a counter value that differs from the expected one at the next read. These faults do not hide for more than the single read that follows the stimulus.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int unsigned NUM_CMP = 3;
  localparam int unsigned FLAG_W  = 6;

  // word indices
  localparam int unsigned W_CTRL = 0;
  localparam int unsigned W_PRE  = 1;
  localparam int unsigned W_STAT = 2;
  localparam int unsigned W_IEN  = 3;
  localparam int unsigned W_CMP1 = 4;
  localparam int unsigned W_CAP1 = 7;
  localparam int unsigned W_CAP2 = 8;
  localparam int unsigned W_CNT  = 9;

  // control bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_ENMOD = 1;
  localparam int unsigned CB_SEL   = 6;
  localparam int unsigned CB_FREE  = 9;
  localparam int unsigned CB_SWR   = 15;

  localparam logic [31:0] CTRL_UNSTORED = 32'h0000_7c14;
  // enable, enable-mode, debug, stop, wait, doze
  localparam logic [31:0] CTRL_SWR_CLR  = 32'h0003_002b;

  // status bit positions
  localparam int unsigned SB_ROV = 5;

  localparam logic [2:0] SEL_IPG  = 3'b001;
  localparam logic [2:0] SEL_HF   = 3'b010;
  localparam logic [2:0] SEL_SLOW = 3'b100;

endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick
  import cmp_timer_pkg::*;
#(
  parameter int unsigned PR_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [2:0]      sel_i,
  input  logic [PR_W-1:0] pr_i,
  input  logic            tick_ipg_i,
  input  logic            tick_hf_i,
  input  logic            tick_slow_i,
  output logic            step_o
);

  logic            src;
  logic            due;
  logic [PR_W-1:0] div_q;

  always_comb begin
    case (sel_i)
      SEL_IPG:  src = tick_ipg_i;
      SEL_HF:   src = tick_hf_i;
      SEL_SLOW: src = tick_slow_i;
      default:  src = 1'b0;
    endcase
  end

  // >= keeps the divider bounded when the prescaler shrinks mid-count
  assign due    = (div_q >= pr_i);
  assign step_o = run_i & src & due;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (clr_i || !run_i) div_q <= '0;
    else if (src)             div_q <= due ? '0 : div_q + 1'b1;
  end

  p_div_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && src && !due) |=> (div_q == $past(div_q) + 1'b1));

  p_div_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && !src) |=> $stable(div_q));

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            step_i,
  input  logic                            zero_i,
  input  logic                            free_run_i,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_i,
  output logic [CNT_W-1:0]                cnt_o,
  output logic [NUM_CMP-1:0]              hit_o,
  output logic                            wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             restart;

  assign restart = step_i & ~free_run_i & (cnt_q == cmp_i[0]);
  assign cnt_nxt = restart ? '0 : cnt_q + 1'b1;
  assign wrap_o  = step_i & ~zero_i & ~restart & (cnt_q == CNT_MAX);

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign hit_o[g] = step_i & ~zero_i & (cnt_nxt == cmp_i[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (zero_i) cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !zero_i) |=> $stable(cnt_q));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !zero_i && free_run_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !free_run_i && cnt_q == cmp_i[0]) |=> (cnt_q == '0));

  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PR_W   = 12,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              tick_ipg_i,
  input  logic              tick_hf_i,
  input  logic              tick_slow_i,
  output logic              irq_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]               widx;
  logic                           unused_addr_lo;
  logic [31:0]                    ctrl_q;
  logic [PR_W-1:0]                pr_q;
  logic [FLAG_W-1:0]              sr_q;
  logic [FLAG_W-1:0]              ien_q;
  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_q;
  logic [31:0]                    ctrl_w;
  logic                           wr_ctrl, wr_pre, wr_stat, wr_ien;
  logic [NUM_CMP-1:0]             wr_cmp;
  logic                           swr_req, en_q, en_rise, zero;
  logic                           step;
  logic [CNT_W-1:0]               cnt;
  logic [NUM_CMP-1:0]             hit;
  logic                           wrap;
  logic [FLAG_W-1:0]              set_vec;
  logic [FLAG_W-1:0]              clr_vec;

  assign widx           = reg_addr_i[ADDR_W-1:2];
  assign unused_addr_lo = ^reg_addr_i[1:0];

  assign wr_ctrl = reg_we_i & (widx == IDX_W'(W_CTRL));
  assign wr_pre  = reg_we_i & (widx == IDX_W'(W_PRE));
  assign wr_stat = reg_we_i & (widx == IDX_W'(W_STAT));
  assign wr_ien  = reg_we_i & (widx == IDX_W'(W_IEN));

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_wsel
    assign wr_cmp[g] = reg_we_i & (widx == IDX_W'(W_CMP1 + g));
  end

  assign ctrl_w  = reg_wdata_i & ~CTRL_UNSTORED;
  assign swr_req = wr_ctrl & ctrl_w[CB_SWR];
  assign en_q    = ctrl_q[CB_EN];
  assign en_rise = wr_ctrl & ~swr_req & ctrl_w[CB_EN] & ~en_q;
  assign zero    = swr_req
                 | (en_rise & ctrl_w[CB_ENMOD])
                 | (wr_cmp[0] & ~ctrl_q[CB_FREE]);

  // control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ctrl_q <= '0;
    else if (swr_req)          ctrl_q <= ctrl_w & ~CTRL_SWR_CLR;
    else if (wr_ctrl)          ctrl_q <= ctrl_w;
    else if (ctrl_q[CB_SWR])   ctrl_q[CB_SWR] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pr_q <= '0;
    else if (swr_req) pr_q <= '0;
    else if (wr_pre)  pr_q <= reg_wdata_i[PR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ien_q <= '0;
    else if (swr_req) ien_q <= '0;
    else if (wr_ien)  ien_q <= reg_wdata_i[FLAG_W-1:0];
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cmp_q[g] <= '0;
      else if (swr_req)   cmp_q[g] <= '1;
      else if (wr_cmp[g]) cmp_q[g] <= reg_wdata_i[CNT_W-1:0];
    end
  end

  // status: hardware set wins over a same-cycle clear
  always_comb begin
    set_vec                = '0;
    set_vec[NUM_CMP-1:0]   = hit;
    set_vec[SB_ROV]        = wrap;
    clr_vec                = wr_stat ? reg_wdata_i[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (swr_req) sr_q <= '0;
    else              sr_q <= (sr_q & ~clr_vec) | set_vec;
  end

  cmp_timer_tick #(
    .PR_W (PR_W)
  ) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (en_q),
    .clr_i       (zero),
    .sel_i       (ctrl_q[CB_SEL +: 3]),
    .pr_i        (pr_q),
    .tick_ipg_i  (tick_ipg_i),
    .tick_hf_i   (tick_hf_i),
    .tick_slow_i (tick_slow_i),
    .step_o      (step)
  );

  cmp_timer_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .zero_i     (zero),
    .free_run_i (ctrl_q[CB_FREE]),
    .cmp_i      (cmp_q),
    .cnt_o      (cnt),
    .hit_o      (hit),
    .wrap_o     (wrap)
  );

  assign irq_o = en_q & (|(sr_q & ien_q));

  always_comb begin
    reg_rdata_o = '0;
    case (widx)
      IDX_W'(W_CTRL):     reg_rdata_o = ctrl_q;
      IDX_W'(W_PRE):      reg_rdata_o = 32'(pr_q);
      IDX_W'(W_STAT):     reg_rdata_o = 32'(sr_q);
      IDX_W'(W_IEN):      reg_rdata_o = 32'(ien_q);
      IDX_W'(W_CMP1):     reg_rdata_o = 32'(cmp_q[0]);
      IDX_W'(W_CMP1 + 1): reg_rdata_o = 32'(cmp_q[1]);
      IDX_W'(W_CMP1 + 2): reg_rdata_o = 32'(cmp_q[2]);
      IDX_W'(W_CAP1):     reg_rdata_o = '0;
      IDX_W'(W_CAP2):     reg_rdata_o = '0;
      IDX_W'(W_CNT):      reg_rdata_o = 32'(cnt);
      default:            reg_rdata_o = '0;
    endcase
  end

  p_irq_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_o);

  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && set_vec == '0) |=> ((sr_q & $past(reg_wdata_i[FLAG_W-1:0])) == '0));

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swr_req && set_vec != '0) |=> ((sr_q & $past(set_vec)) == $past(set_vec)));

  p_swr_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_req |=> (sr_q == '0 && ien_q == '0 && pr_q == '0 && cnt == '0 && !en_q));

  p_swr_self_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CB_SWR] && !swr_req) |=> !ctrl_q[CB_SWR]);

  p_cmp1_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmp[0] && !ctrl_q[CB_FREE]) |=> (cnt == '0));

  p_unstored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> ((ctrl_q & CTRL_UNSTORED) == '0));

endmodule

// File: tb/cmp_timer_tb.sv
`timescale 1ns/1ps
module cmp_timer_tb;

  localparam int unsigned CNT_W = 8;
  localparam int unsigned A_CTRL = 6'h00, A_PRE = 6'h04, A_STAT = 6'h08, A_IEN = 6'h0c;
  localparam int unsigned A_CMP1 = 6'h10, A_CMP2 = 6'h14, A_CMP3 = 6'h18;
  localparam int unsigned A_CAP1 = 6'h1c, A_CAP2 = 6'h20, A_CNT = 6'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        t_ipg = 1'b0, t_hf = 1'b0, t_slow = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // scoreboard: kind 0 = read word, 1 = irq pin
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          kind_q[$];
  logic        rd_req = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer #(.CNT_W(CNT_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .tick_ipg_i  (t_ipg),
    .tick_hf_i   (t_hf),
    .tick_slow_i (t_slow),
    .irq_o       (irq)
  );

  // monitor
  always @(negedge clk) begin
    if (rd_req && exp_q.size() > 0) begin
      logic [31:0] e;
      logic [31:0] a;
      string t;
      bit k;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      k = kind_q.pop_front();
      a = k ? {31'd0, irq} : rdata;
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic wr_tick(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d; t_ipg = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; t_ipg = 1'b0;
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      t_ipg = (src == 0); t_hf = (src == 1); t_slow = (src == 2);
      @(posedge clk); #1;
      t_ipg = 1'b0; t_hf = 1'b0; t_slow = 1'b0;
    end
  endtask

  task automatic chk(input logic [5:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    addr = a; exp_q.push_back(e); tag_q.push_back(t); kind_q.push_back(1'b0);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(posedge clk); #1;
    exp_q.push_back({31'd0, e}); tag_q.push_back(t); kind_q.push_back(1'b1);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 hardware reset values
    chk(A_CTRL, 32'h0, "R12 ctrl after reset");
    chk(A_CMP1, 32'h0, "R12 cmp1 after reset");
    chk(A_STAT, 32'h0, "R12 status after reset");
    chk(A_CNT,  32'h0, "R12 counter after reset");
    chk_irq(1'b0, "R5 irq after reset");

    // R12 unstored control bits
    wr(A_CTRL, 32'hffff_7fff);
    chk(A_CTRL, 32'hffff_03eb, "R12 unstored ctrl bits");
    wr(A_CTRL, 32'h0);

    // R1 capture and counter words
    wr(A_CAP1, 32'hffff_ffff);
    wr(A_CAP2, 32'h1234_5678);
    wr(A_CNT,  32'h0000_0055);
    chk(A_CAP1, 32'h0, "R1 capture 1 reads zero");
    chk(A_CAP2, 32'h0, "R1 capture 2 reads zero");
    chk(A_CNT,  32'h0, "R1 counter write ignored");

    // R3 prescaler divide by 3
    wr(A_PRE, 32'h2);
    chk(A_PRE, 32'h2, "R1 prescaler word");
    wr(A_CTRL, 32'h241);
    pulse(0, 9);
    chk(A_CNT, 32'd3, "R3 nine ticks at prescale 2");

    // R2 unselected sources
    pulse(1, 5);
    pulse(2, 3);
    chk(A_CNT, 32'd3, "R2 unselected sources ignored");
    wr(A_CTRL, 32'h301);
    pulse(2, 3);
    chk(A_CNT, 32'd4, "R2 slow source selected");
    pulse(0, 3);
    chk(A_CNT, 32'd4, "R2 ipg ignored when slow selected");
    wr(A_CTRL, 32'h2c1);
    pulse(0, 3); pulse(1, 3); pulse(2, 3);
    chk(A_CNT, 32'd4, "R2 undefined source code holds");

    // R6 / R5 compare 2 flag and interrupt
    wr(A_PRE, 32'h0);
    wr(A_CTRL, 32'h241);
    wr(A_CMP2, 32'd7);
    wr(A_IEN, 32'h02);
    pulse(0, 2);
    chk(A_CNT, 32'd6, "R3 prescale 0 advance");
    chk(A_STAT, 32'h0, "R6 no flag before match");
    chk_irq(1'b0, "R5 irq idle before match");
    pulse(0, 1);
    chk(A_STAT, 32'h02, "R6 compare 2 flag");
    chk_irq(1'b1, "R5 irq on enabled flag");

    // R4 write-zero and unrelated bits
    wr(A_STAT, 32'h00);
    wr(A_STAT, 32'h01);
    chk(A_STAT, 32'h02, "R4 zero and other bits leave flag");
    wr(A_IEN, 32'h0);
    chk_irq(1'b0, "R5 irq masked by enable");
    wr(A_IEN, 32'h2);
    wr(A_CTRL, 32'h240);
    chk_irq(1'b0, "R5 irq gated by timer enable");
    wr(A_STAT, 32'h02);
    chk(A_STAT, 32'h0, "R4 write one clears");

    // R10 enable mode
    wr(A_CTRL, 32'h241);
    chk(A_CNT, 32'd7, "R10 resume without enable mode");
    pulse(0, 2);
    chk(A_CNT, 32'd9, "R10 counts after resume");
    wr(A_CTRL, 32'h240);
    wr(A_CTRL, 32'h243);
    chk(A_CNT, 32'd0, "R10 restart with enable mode");
    pulse(0, 1);
    chk(A_CNT, 32'd1, "R10 counts after restart");

    // R9 / R7 restart mode
    wr(A_CTRL, 32'h043);
    wr(A_CMP1, 32'd4);
    chk(A_CNT, 32'd0, "R9 compare 1 write restarts");
    pulse(0, 4);
    chk(A_CNT, 32'd4, "R7 reaches compare 1");
    chk(A_STAT, 32'h01, "R6 compare 1 flag");
    pulse(0, 1);
    chk(A_CNT, 32'd0, "R7 returns to zero");
    chk(A_STAT, 32'h05, "R6 compare 3 at zero after restart");
    wr(A_STAT, 32'h3f);

    // R4 set wins over clear
    pulse(0, 3);
    wr_tick(A_STAT, 32'h01);
    chk(A_CNT, 32'd4, "R4 counter at match during clear");
    chk(A_STAT, 32'h01, "R4 set wins over clear");
    wr(A_STAT, 32'h01);
    chk(A_STAT, 32'h0, "R4 clear after set");

    // R8 rollover in free-run
    wr(A_CTRL, 32'h241);
    wr(A_CMP1, 32'h10);
    chk(A_CNT, 32'd4, "R9 compare 1 write in free-run keeps count");
    wr(A_CMP3, 32'h80);
    pulse(0, 251);
    chk(A_CNT, 32'hff, "R8 counter at max");
    chk(A_STAT, 32'h07, "R6 all compare flags on the way");
    pulse(0, 1);
    chk(A_CNT, 32'h0, "R8 wrap to zero");
    chk(A_STAT, 32'h27, "R8 rollover flag");

    // R11 software reset
    wr(A_PRE, 32'h5);
    wr(A_IEN, 32'h3f);
    chk_irq(1'b1, "R5 irq before soft reset");
    pulse(0, 6);
    chk(A_CNT, 32'd1, "R3 prescale 5 advance");
    wr(A_CTRL, 32'h0001_8249);
    chk(A_CTRL, 32'h0000_0240, "R11 ctrl kept fields, swr self-clear");
    chk(A_PRE,  32'h0, "R11 prescaler cleared");
    chk(A_IEN,  32'h0, "R11 enables cleared");
    chk(A_STAT, 32'h0, "R11 status cleared");
    chk(A_CNT,  32'h0, "R11 counter cleared");
    chk(A_CMP1, 32'hff, "R11 compare 1 all ones");
    chk(A_CMP2, 32'hff, "R11 compare 2 all ones");
    chk(A_CMP3, 32'hff, "R11 compare 3 all ones");
    chk_irq(1'b0, "R11 irq low after soft reset");
    pulse(0, 2);
    chk(A_CNT, 32'h0, "R11 timer left disabled");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule